// File: doc/BRIEF.md
# Shared-Period Multi-Output PWM Group

This block is a group of pulse-width outputs driven from one 16-bit up-counter. A single period value sets the length of every cycle. Each output has its own compare value, so the outputs all share the same repetition rate but can each have a different high time. Software programs the period and the compare values through a small register port and then sets the run bit. The counter then starts counting up from zero.

Each output rises when the counter restarts at zero. It stays high up to and including the count that equals its compare value, and it falls on the next count. A compare value at or above the period holds the output high for the whole cycle. The group cannot produce a fully low waveform: a compare value of zero still gives a one-count pulse at the start of every cycle.

New period and compare values wait in holding registers. They move into the working registers only at a cycle boundary, so a cycle that is already running is never cut short or distorted.

Top module: `pwm_group`

## Requirements
- R1: After reset the run bit, the period, every compare value, `count_o` and `pwm_o` are all zero.
- R2: While running, `count_o` steps by one per clock from 0 up to the working period P and then returns to 0, so one cycle lasts P+1 clocks.
- R3: For a working compare value D below the working period, an output is high while `count_o` is less than or equal to D and low for the rest of the cycle, which gives D+1 high clocks per cycle.
- R4: A compare value of 0 gives a one-clock high pulse at count 0 of every cycle, never a constant low.
- R5: A compare value greater than or equal to the working period holds its output high for the whole cycle. A period of 0 therefore makes every active output constant high.
- R6: All active outputs use the same counter and period: every output whose compare value is below the period is high at count 0.
- R7: Writes to the period or a compare value show up in readback on the next clock. They take effect on the outputs only from the clock after the counter matches the old period, at the moment the count returns to 0.
- R8: Writing 0 to the run bit sets `count_o` and `pwm_o` to zero from the next clock. Writing 1 restarts the count from 0 using the values in the holding registers.
- R9: Only the first NUM_OUT outputs are active (NUM_OUT from 1 to 4). A compare register above that number ignores writes and reads back as 0, and its `pwm_o` bit stays 0.
- R10: The register map is as follows. Address 0 holds the run bit in bit 0. Address 1 holds the period. Addresses 2 to 5 hold the compare values for outputs 0 to 3. Reads return the holding registers, and addresses 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address, used for both reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, combinational |
| count_o | output | 16 | Current counter value |
| pwm_o | output | 4 | Waveform outputs, one per compare register |

## Verification
Some properties are checked on every cycle. The counter never goes past the working period, and it returns to zero after a match. The working period and compare values stay fixed inside a cycle. An output falls on the clock after its match. Every output is high at the start of each new cycle. A holding register only changes when it is written. Other behaviour can only be shown by the bench scenarios, which compare each cycle against a behavioural model. These include the exact count of high clocks for a given compare value, the constant-high case for a large value or a period of 0, and the one-clock pulse for a compare value of 0. The scenarios also cover a period change made in the middle of a cycle, stopping and restarting the counter, and the outputs above NUM_OUT staying dead.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;
  localparam int unsigned MAX_CH    = 4;
  localparam int unsigned ADDR_W    = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam int unsigned       A_DUTY0  = 2;
endpackage

// File: rtl/pwmg_regs.sv
module pwmg_regs
  import pwmg_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned NUM_OUT = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DW-1:0]                  wr_data,
  output logic                           en_q,
  output logic                           en_nxt,
  output logic [DW-1:0]                  per_sh,
  output logic [MAX_CH-1:0][DW-1:0]      duty_sh,
  output logic [DW-1:0]                  rd_data
);

  logic [DW-1:0] per_nxt;

  always_comb begin
    en_nxt = en_q;
    if (wr_en && addr == A_CTRL) en_nxt = wr_data[0];
  end

  always_comb begin
    per_nxt = per_sh;
    if (wr_en && addr == A_PERIOD) per_nxt = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      per_sh <= '0;
    end else begin
      en_q   <= en_nxt;
      per_sh <= per_nxt;
    end
  end

  for (genvar i = 0; i < MAX_CH; i++) begin : g_shadow
    if (i < NUM_OUT) begin : g_live
      logic [DW-1:0] d_nxt;
      logic          hit;
      assign hit = wr_en && (addr == ADDR_W'(A_DUTY0 + i));
      always_comb begin
        d_nxt = duty_sh[i];
        if (hit) d_nxt = wr_data;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) duty_sh[i] <= '0;
        else        duty_sh[i] <= d_nxt;
      end
    end else begin : g_dead
      assign duty_sh[i] = '0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == A_CTRL)   rd_data = {{(DW-1){1'b0}}, en_q};
    if (addr == A_PERIOD) rd_data = per_sh;
    for (int i = 0; i < MAX_CH; i++) begin
      if (addr == ADDR_W'(A_DUTY0 + i)) rd_data = duty_sh[i];
    end
  end

  // R7: holding period only moves on a write to it
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_PERIOD) |=> $stable(per_sh));

endmodule

// File: rtl/pwmg_counter.sv
module pwmg_counter #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_q,
  input  logic          en_nxt,
  input  logic [DW-1:0] per_sh,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] per_act,
  output logic          load
);

  logic          at_end;
  logic [DW-1:0] cnt_nxt;
  logic [DW-1:0] per_nxt;

  assign at_end = (cnt == per_act);
  assign load   = !en_q || at_end;

  always_comb begin
    if (!en_q || !en_nxt || at_end) cnt_nxt = '0;
    else                            cnt_nxt = cnt + DW'(1);
  end

  always_comb begin
    per_nxt = per_act;
    if (load) per_nxt = per_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per_act <= '0;
    end else begin
      cnt     <= cnt_nxt;
      per_act <= per_nxt;
    end
  end

  // R2: count never passes the working period
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);

  // R2: a match returns the count to zero
  assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && at_end) |=> (cnt == '0));

  // R8: stopped counter sits at zero
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (cnt == '0));

  // R7: working period is fixed inside a running cycle
  assert_period_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && !$past(at_end)) |-> $stable(per_act));

endmodule

// File: rtl/pwmg_channel.sv
module pwmg_channel #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_q,
  input  logic          load,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] per_act,
  input  logic [DW-1:0] duty_sh,
  output logic          pwm
);

  logic [DW-1:0] duty_act;
  logic [DW-1:0] duty_nxt;
  logic          full_on;
  logic          in_high;

  always_comb begin
    duty_nxt = duty_act;
    if (load) duty_nxt = duty_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) duty_act <= '0;
    else        duty_act <= duty_nxt;
  end

  assign full_on = (duty_act >= per_act);
  assign in_high = (cnt <= duty_act);
  assign pwm     = en_q && (full_on || in_high);

  // R3: output falls on the clock after its match
  assert_low_after_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt == duty_act && duty_act < per_act) |=> !pwm);

  // R4: every new cycle starts high, so no all-low waveform
  assert_restart_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && $past(cnt == per_act)) |-> pwm);

  // R7: working compare value is fixed inside a running cycle
  assert_duty_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && !$past(load)) |-> $stable(duty_act));

endmodule

// File: rtl/pwm_group.sv
module pwm_group
  import pwmg_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  output logic [DW-1:0]      count_o,
  output logic [3:0]         pwm_o
);

  logic [1:0]                 rst_pipe;
  logic                       rst_sync_n;
  logic                       en_q;
  logic                       en_nxt;
  logic [DW-1:0]              per_sh;
  logic [MAX_CH-1:0][DW-1:0]  duty_sh;
  logic [DW-1:0]              cnt;
  logic [DW-1:0]              per_act;
  logic                       load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  pwmg_regs #(.DW(DW), .NUM_OUT(NUM_OUT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .en_q    (en_q),
    .en_nxt  (en_nxt),
    .per_sh  (per_sh),
    .duty_sh (duty_sh),
    .rd_data (rd_data)
  );

  pwmg_counter #(.DW(DW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_q    (en_q),
    .en_nxt  (en_nxt),
    .per_sh  (per_sh),
    .cnt     (cnt),
    .per_act (per_act),
    .load    (load)
  );

  for (genvar i = 0; i < MAX_CH; i++) begin : g_ch
    if (i < NUM_OUT) begin : g_live
      pwmg_channel #(.DW(DW)) u_ch (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .en_q    (en_q),
        .load    (load),
        .cnt     (cnt),
        .per_act (per_act),
        .duty_sh (duty_sh[i]),
        .pwm     (pwm_o[i])
      );
    end else begin : g_dead
      assign pwm_o[i] = 1'b0;
    end
  end

  assign count_o = cnt;

endmodule

// File: tb/pwm_group_test.sv
`timescale 1ns/1ps
module pwm_group_test;
  localparam int NUM = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [15:0] count_o;
  logic [3:0]  pwm_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_en, m_per_sh, m_per_a, m_cnt;
  int m_duty_sh[4];
  int m_duty_a[4];

  always #2.5 clk = ~clk;

  pwm_group #(.DW(16), .NUM_OUT(NUM)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .count_o(count_o), .pwm_o(pwm_o)
  );

  function automatic bit exp_pwm(int i);
    if (i >= NUM || m_en == 0) return 0;
    if (m_duty_a[i] >= m_per_a) return 1;
    return m_cnt <= m_duty_a[i];
  endfunction

  function automatic int exp_rd(int a);
    if (a == 0) return m_en;
    if (a == 1) return m_per_sh;
    if (a >= 2 && a <= 5 && (a - 2) < NUM) return m_duty_sh[a-2];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_per_sh = 0; m_per_a = 0; m_cnt = 0;
      for (int i = 0; i < 4; i++) begin m_duty_sh[i] = 0; m_duty_a[i] = 0; end
    end else begin
      if (m_en == 0 || m_cnt == m_per_a) begin
        m_cnt = 0;
        m_per_a = m_per_sh;
        for (int i = 0; i < 4; i++) m_duty_a[i] = m_duty_sh[i];
      end else begin
        m_cnt = m_cnt + 1;
      end
      if (wr_en) begin
        if (addr == 0) m_en = int'(wr_data[0]);
        else if (addr == 1) m_per_sh = int'(wr_data);
        else if (addr <= 5 && (int'(addr) - 2) < NUM) m_duty_sh[addr-2] = int'(wr_data);
      end
      if (m_en == 0) m_cnt = 0;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "count", int'(count_o), m_cnt);
      for (int i = 0; i < 4; i++) chk(cur_req, $sformatf("pwm[%0d]", i), int'(pwm_o[i]), int'(exp_pwm(i)));
      chk(cur_req, "rd_data", int'(rd_data), exp_rd(int'(addr)));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      done = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    wr_en = 1; addr = 3'(a); wr_data = 16'(d);
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic wait_zero();
    do @(negedge clk); while (count_o != 0);
  endtask

  task automatic sync_new();
    wait_zero();
    @(negedge clk);
    wait_zero();
  endtask

  task automatic highs(int ch, int n, string req, int exp);
    int h = 0;
    h += int'(pwm_o[ch]);
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      h += int'(pwm_o[ch]);
    end
    chk(req, $sformatf("high clocks ch%0d", ch), h, exp);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; addr = 0; wr_data = 0;
    repeat (5) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    cur_req = "R1";
    chk("R1", "count", int'(count_o), 0);
    chk("R1", "pwm", int'(pwm_o), 0);
    for (int a = 0; a < 8; a++) begin
      #1 addr = 3'(a);
      @(negedge clk);
      chk("R1", $sformatf("rd addr %0d", a), int'(rd_data), 0);
    end

    // R2 R3 R4 R5 R6: period 9, compares 3, 0, 9
    cur_req = "R2";
    wr(1, 9); wr(2, 3); wr(3, 0); wr(4, 9);
    wr(0, 1);
    wait_zero();
    chk("R6", "all live outputs high at count 0", int'(pwm_o[2:0]), 3'b111);
    repeat (9) @(negedge clk);
    chk("R2", "count at end of cycle", int'(count_o), 9);
    @(negedge clk);
    chk("R2", "count after wrap", int'(count_o), 0);
    cur_req = "R3";
    wait_zero(); highs(0, 10, "R3", 4);
    cur_req = "R4";
    wait_zero(); highs(1, 10, "R4", 1);
    cur_req = "R5";
    wait_zero(); highs(2, 10, "R5", 10);

    // R7: shrink period mid-cycle
    cur_req = "R7";
    wait_zero();
    repeat (3) @(negedge clk);
    #1 addr = 3'd1;
    wr(1, 5);
    @(negedge clk);
    chk("R10", "period readback", int'(rd_data), 5);
    chk("R7", "old cycle still running", int'(count_o) > 5 ? 1 : 0, 1);
    wait_zero();
    repeat (5) @(negedge clk);
    chk("R7", "new period end", int'(count_o), 5);
    wait_zero(); highs(0, 6, "R7", 4);
    wait_zero(); highs(2, 6, "R5", 6);

    // R8: stop and restart
    cur_req = "R8";
    wr(0, 0);
    @(negedge clk);
    chk("R8", "count stopped", int'(count_o), 0);
    chk("R8", "pwm stopped", int'(pwm_o), 0);
    repeat (4) @(negedge clk);
    chk("R8", "pwm still low", int'(pwm_o), 0);
    wr(0, 1);
    @(negedge clk);
    chk("R8", "count after restart", int'(count_o), 1);
    chk("R8", "ch0 high after restart", int'(pwm_o[0]), 1);

    // R9 R10: dead channel and unmapped addresses
    cur_req = "R9";
    wr(5, 16'h1234);
    #1 addr = 3'd5;
    @(negedge clk);
    chk("R9", "dead compare readback", int'(rd_data), 0);
    chk("R9", "dead output", int'(pwm_o[3]), 0);
    cur_req = "R10";
    wr(7, 16'hBEEF);
    #1 addr = 3'd7;
    @(negedge clk);
    chk("R10", "unmapped readback", int'(rd_data), 0);
    #1 addr = 3'd2;
    @(negedge clk);
    chk("R10", "compare 0 readback", int'(rd_data), 3);

    // wide values: period 0x100, compares 0xFF, 0, 0xF000
    cur_req = "R3";
    wr(1, 16'h0100); wr(2, 16'h00FF); wr(3, 0); wr(4, 16'hF000);
    sync_new(); highs(0, 257, "R3", 256);
    wait_zero(); highs(1, 257, "R4", 1);
    wait_zero(); highs(2, 257, "R5", 257);

    // period 0: constant high on live outputs
    cur_req = "R5";
    wr(1, 0);
    sync_new();
    repeat (3) @(negedge clk);
    chk("R5", "period 0 outputs", int'(pwm_o), 4'b0111);
    chk("R5", "period 0 count", int'(count_o), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule